// File: doc/BRIEF.md
# Error Classification and Signaling Gate

This block sits beside the error detectors of an endpoint or switch port. It accepts one detected error event at a time. Each event carries a 32-bit status vector, a correctable flag, an advisory-eligible flag and a 16-bit source ID. The block checks that the event names exactly one supported error. It then updates the device-level detected flags and the correctable and uncorrectable status registers. Next it applies the mask and severity registers and the reporting enables. From these it decides whether a correctable, nonfatal or fatal error message leaves the block. Unmasked uncorrectable errors, and unmasked advisory errors, also raise a log request towards a separate logging unit. If that unit answers with an overflow, the block issues a follow-up correctable header-log-overflow event of its own.

The controller is a three-state machine:
- `ST_IDLE` (ready) moves to `ST_EMIT` on an accepted event.
- `ST_EMIT` (message and log strobes visible; the uncorrectable status bit is committed at the end of it) returns to `ST_IDLE`. If the logging unit reports overflow while a message is out, it moves to `ST_OVF` instead.
- `ST_OVF` (synthetic overflow event classified) always moves to `ST_EMIT`.

A rejected event leaves the machine in `ST_IDLE`.

Top module: `err_gate`

## Requirements
- R1: The event vector is ANDed with the supported set for its class: bits 15:0 for uncorrectable events, bits 7:0 for correctable ones. If the result is zero or has more than one bit set, the event is dropped. Nothing changes: no flag, no status bit, no message, no log request, and `evt_ready` stays high.
- R2: An uncorrectable error is fatal when its bit is set in the severity register, and nonfatal otherwise. That register resets to 0x118B, which makes bits 0, 1, 3, 7, 8 and 12 fatal. A write through `sev_we`/`sev_wdata` replaces it. Fatal classification overrides the advisory flag.
- R3: A correctable error sets `dev_status[0]` and its bit in `cor_status`, both visible one cycle after acceptance. If that bit is set in `cor_mask`, no message is sent.
- R4: A message of correctable severity needs `cor_rep_en`. When the originating error is unsupported-request (uncorrectable bit 10), it also needs `ur_rep_en`.
- R5: An uncorrectable error, when not downgraded, sets `dev_status[2]` if fatal and `dev_status[1]` if nonfatal. Bit 10 also sets `dev_status[3]`, on both the uncorrectable and the advisory path.
- R6: An uncorrectable error whose bit is set in `unc_mask` sets its `unc_status` bit. It is neither logged nor signaled.
- R7: An unmasked uncorrectable error pulses `log_req` one cycle after acceptance, with `log_bit` equal to the error's bit and `log_src` equal to the source ID. Its `unc_status` bit appears one cycle later, so the logging unit sees the status as it was before this error.
- R8: An unmasked uncorrectable error is signaled when `serr_en` is set, or when the enable for its severity is set (`fatal_rep_en` or `nf_rep_en`). A bit-10 error with neither `ur_rep_en` nor `serr_en` is never signaled.
- R9: A nonfatal error flagged advisory-eligible is handled as a correctable error on `cor_status` bit 5. If bit 5 is masked, nothing else happens. Otherwise the original bit is set in `unc_status` (deferred as in R7), `log_req` pulses only if that bit is clear in `unc_mask`, and a correctable-severity message follows R4.
- R10: A follow-up event starts when `log_ovf` is high in a cycle where `log_req` and `msg_valid` are both high. Two cycles after the first message, it sets `cor_status` bit 7 and `dev_status[0]`. If enabled and unmasked, it sends a correctable message with source ID 0. Without a message in that cycle, no follow-up occurs.
- R11: `evt_ready` is high only when idle. It drops for the cycle after an accepted event, and also while a follow-up is pending, so accepted events are at least two cycles apart.
- R12: `msg_valid` is a single-cycle strobe. `msg_sev` is one-hot: bit 0 correctable, bit 1 nonfatal, bit 2 fatal.
- R13: `dev_clr`, `cor_clr` and `unc_clr` clear the matching status bits one cycle later (write-one-to-clear). A set in the same cycle wins over a clear. Status bits never drop otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Error event offered |
| evt_ready | output | 1 | Block can accept an event |
| evt_status | input | 32 | Error bit vector of the event |
| evt_is_cor | input | 1 | Event is of the correctable class |
| evt_adv_ok | input | 1 | Nonfatal event may be downgraded to advisory |
| evt_src | input | 16 | Requester/source ID of the event |
| sev_we | input | 1 | Severity register write strobe |
| sev_wdata | input | 16 | Severity register write value |
| unc_mask | input | 16 | Uncorrectable error mask |
| cor_mask | input | 8 | Correctable error mask |
| serr_en | input | 1 | System-error reporting enable |
| cor_rep_en | input | 1 | Correctable reporting enable |
| nf_rep_en | input | 1 | Nonfatal reporting enable |
| fatal_rep_en | input | 1 | Fatal reporting enable |
| ur_rep_en | input | 1 | Unsupported-request reporting enable |
| dev_clr | input | 4 | Write-one-to-clear for device flags |
| cor_clr | input | 8 | Write-one-to-clear for correctable status |
| unc_clr | input | 16 | Write-one-to-clear for uncorrectable status |
| dev_status | output | 4 | Detected flags: 0 corr, 1 nonfatal, 2 fatal, 3 unsupported request |
| cor_status | output | 8 | Correctable error status |
| unc_status | output | 16 | Uncorrectable error status |
| sev_reg | output | 16 | Current severity register |
| msg_valid | output | 1 | Error message strobe |
| msg_sev | output | 3 | One-hot message severity |
| msg_src | output | 16 | Source ID of the message |
| log_req | output | 1 | Log request strobe to the logging unit |
| log_bit | output | 16 | Uncorrectable bit to log |
| log_src | output | 16 | Source ID to log |
| log_ovf | input | 1 | Logging unit overflow, valid with log_req |

## Verification
Message, log strobes, device flags and correctable status are all due one cycle after the accepting edge. The uncorrectable status bit is due one cycle later still. A follow-up overflow message is due two cycles after the first message, and `evt_ready` returns the cycle after that. The bench drives every input on the falling edge and samples on the following falling edge for each of these counts. At the log-request sample it also checks that `unc_status` is still clear, which pins down the ordering of log before status. Each vector starts from cleared status, so every expected register value is exact rather than a subset.

// File: rtl/err_gate_pkg.sv
package err_gate_pkg;

    localparam int IN_W  = 32;   // width of the incoming error vector
    localparam int UNC_W = 16;   // uncorrectable status width
    localparam int COR_W = 8;    // correctable status width
    localparam int SRC_W = 16;   // source ID width
    localparam int DEV_W = 4;    // device detected flags
    localparam int SEV_W = 3;    // one-hot message severity

    // bit positions the behaviour depends on
    localparam int UR_BIT   = 10;  // unsupported request (uncorrectable)
    localparam int ADV_BIT  = 5;   // advisory nonfatal (correctable)
    localparam int HOVF_BIT = 7;   // header log overflow (correctable)

    localparam int DEV_COR = 0;
    localparam int DEV_NF  = 1;
    localparam int DEV_FAT = 2;
    localparam int DEV_UR  = 3;

    localparam logic [SEV_W-1:0] SEV_COR = 3'b001;
    localparam logic [SEV_W-1:0] SEV_NF  = 3'b010;
    localparam logic [SEV_W-1:0] SEV_FAT = 3'b100;

    localparam logic [IN_W-1:0]  UNC_SUP = IN_W'({UNC_W{1'b1}});
    localparam logic [IN_W-1:0]  COR_SUP = IN_W'({COR_W{1'b1}});
    localparam logic [COR_W-1:0] ADV_ONEHOT  = COR_W'(1) << ADV_BIT;
    localparam logic [IN_W-1:0]  HOVF_EVENT  = IN_W'(1) << HOVF_BIT;

    // link protocol, surprise down, flow control, rx overflow, malformed, internal
    localparam logic [UNC_W-1:0] SEV_RESET =
        (UNC_W'(1) << 0) | (UNC_W'(1) << 1) | (UNC_W'(1) << 3) |
        (UNC_W'(1) << 7) | (UNC_W'(1) << 8) | (UNC_W'(1) << 12);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EMIT = 2'd1,
        ST_OVF  = 2'd2
    } gate_state_e;

    typedef struct packed {
        logic              ok;
        logic [COR_W-1:0]  cor_set;
        logic [UNC_W-1:0]  unc_set;
        logic [DEV_W-1:0]  dev_set;
        logic              log;
        logic [UNC_W-1:0]  log_bit;
        logic              msg;
        logic [SEV_W-1:0]  sev;
    } decision_t;

endpackage

// File: rtl/err_gate_classify.sv
module err_gate_classify
    import err_gate_pkg::*;
(
    input  logic [IN_W-1:0]  vec_i,
    input  logic             is_cor_i,
    input  logic             adv_ok_i,
    input  logic [UNC_W-1:0] sev_i,
    input  logic [UNC_W-1:0] unc_mask_i,
    input  logic [COR_W-1:0] cor_mask_i,
    input  logic             serr_en_i,
    input  logic             cor_en_i,
    input  logic             nf_en_i,
    input  logic             fatal_en_i,
    input  logic             ur_en_i,
    output decision_t        dec_o
);

    logic [IN_W-1:0]  v;
    logic [UNC_W-1:0] uv;
    logic [COR_W-1:0] cbit;
    logic             single;
    logic             fatal;
    logic             adv;
    logic             ur;
    logic             cmasked;
    logic             umasked;

    always_comb begin
        v       = vec_i & (is_cor_i ? COR_SUP : UNC_SUP);
        single  = (v != '0) && ((v & (v - IN_W'(1))) == '0);
        uv      = v[UNC_W-1:0];
        fatal   = !is_cor_i && ((uv & sev_i) != '0);
        adv     = !is_cor_i && !fatal && adv_ok_i;
        ur      = !is_cor_i && uv[UR_BIT];
        cbit    = is_cor_i ? v[COR_W-1:0] : ADV_ONEHOT;
        cmasked = (cbit & cor_mask_i) != '0;
        umasked = (uv & unc_mask_i) != '0;

        dec_o         = '0;
        dec_o.log_bit = uv;
        if (single) begin
            dec_o.ok             = 1'b1;
            dec_o.dev_set[DEV_UR] = ur;
            if (is_cor_i || adv) begin
                dec_o.dev_set[DEV_COR] = 1'b1;
                dec_o.cor_set          = cbit;
                dec_o.sev              = SEV_COR;
                if (!cmasked) begin
                    if (adv) begin
                        dec_o.unc_set = uv;
                        dec_o.log     = !umasked;
                    end
                    dec_o.msg = cor_en_i && !(ur && !ur_en_i);
                end
            end else begin
                dec_o.dev_set[DEV_FAT] = fatal;
                dec_o.dev_set[DEV_NF]  = !fatal;
                dec_o.unc_set          = uv;
                dec_o.sev              = fatal ? SEV_FAT : SEV_NF;
                dec_o.log              = !umasked;
                dec_o.msg              = !umasked
                                      && !(ur && !ur_en_i && !serr_en_i)
                                      && (serr_en_i || (fatal ? fatal_en_i : nf_en_i));
            end
        end
    end

endmodule

// File: rtl/err_gate_status.sv
module err_gate_status
    import err_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEV_W-1:0] dev_set_i,
    input  logic [COR_W-1:0] cor_set_i,
    input  logic [UNC_W-1:0] unc_set_i,
    input  logic [DEV_W-1:0] dev_clr_i,
    input  logic [COR_W-1:0] cor_clr_i,
    input  logic [UNC_W-1:0] unc_clr_i,
    input  logic             sev_we_i,
    input  logic [UNC_W-1:0] sev_wdata_i,
    output logic [DEV_W-1:0] dev_o,
    output logic [COR_W-1:0] cor_o,
    output logic [UNC_W-1:0] unc_o,
    output logic [UNC_W-1:0] sev_o
);

    logic [DEV_W-1:0] dev_q;
    logic [COR_W-1:0] cor_q;
    logic [UNC_W-1:0] unc_q;
    logic [UNC_W-1:0] sev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_q <= '0;
            cor_q <= '0;
            unc_q <= '0;
            sev_q <= SEV_RESET;
        end else begin
            dev_q <= (dev_q & ~dev_clr_i) | dev_set_i;
            cor_q <= (cor_q & ~cor_clr_i) | cor_set_i;
            unc_q <= (unc_q & ~unc_clr_i) | unc_set_i;
            if (sev_we_i) sev_q <= sev_wdata_i;
        end
    end

    assign dev_o = dev_q;
    assign cor_o = cor_q;
    assign unc_o = unc_q;
    assign sev_o = sev_q;

    // R13
    cor_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cor_clr_i == '0) |=> ((~cor_q & $past(cor_q)) == '0));
    // R13
    unc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unc_clr_i == '0) |=> ((~unc_q & $past(unc_q)) == '0));
    // R13
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cor_set_i != '0) |=> ((cor_q & $past(cor_set_i)) == $past(cor_set_i)));
    // R2
    sev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sev_we_i |=> $stable(sev_q));

endmodule

// File: rtl/err_gate_ctrl.sv
module err_gate_ctrl
    import err_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid_i,
    output logic             evt_ready_o,
    input  logic [IN_W-1:0]  evt_status_i,
    input  logic             evt_is_cor_i,
    input  logic             evt_adv_ok_i,
    input  logic [SRC_W-1:0] evt_src_i,
    input  logic             log_ovf_i,
    output logic [IN_W-1:0]  cls_vec_o,
    output logic             cls_is_cor_o,
    output logic             cls_adv_o,
    input  decision_t        dec_i,
    output logic [DEV_W-1:0] dev_set_o,
    output logic [COR_W-1:0] cor_set_o,
    output logic [UNC_W-1:0] unc_set_o,
    output logic             msg_valid_o,
    output logic [SEV_W-1:0] msg_sev_o,
    output logic [SRC_W-1:0] msg_src_o,
    output logic             log_req_o,
    output logic [UNC_W-1:0] log_bit_o,
    output logic [SRC_W-1:0] log_src_o
);

    gate_state_e      state_q, state_d;
    logic             take;
    logic [UNC_W-1:0] pend_q;

    // the follow-up overflow event replaces the external one in ST_OVF
    always_comb begin
        if (state_q == ST_OVF) begin
            cls_vec_o    = HOVF_EVENT;
            cls_is_cor_o = 1'b1;
            cls_adv_o    = 1'b0;
        end else begin
            cls_vec_o    = evt_status_i;
            cls_is_cor_o = evt_is_cor_i;
            cls_adv_o    = evt_adv_ok_i;
        end
    end

    assign evt_ready_o = (state_q == ST_IDLE);
    assign take = dec_i.ok && (((state_q == ST_IDLE) && evt_valid_i) || (state_q == ST_OVF));

    assign dev_set_o = take ? dec_i.dev_set : '0;
    assign cor_set_o = take ? dec_i.cor_set : '0;
    assign unc_set_o = (state_q == ST_EMIT) ? pend_q : '0;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take) state_d = ST_EMIT;
            ST_EMIT: state_d = (log_req_o && msg_valid_o && log_ovf_i) ? ST_OVF : ST_IDLE;
            ST_OVF:  state_d = ST_EMIT;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid_o <= 1'b0;
            msg_sev_o   <= '0;
            msg_src_o   <= '0;
            log_req_o   <= 1'b0;
            log_bit_o   <= '0;
            log_src_o   <= '0;
            pend_q      <= '0;
        end else begin
            msg_valid_o <= take && dec_i.msg;
            log_req_o   <= take && dec_i.log;
            if (take) begin
                msg_sev_o <= dec_i.sev;
                msg_src_o <= (state_q == ST_OVF) ? '0 : evt_src_i;
                log_bit_o <= dec_i.log_bit;
                log_src_o <= evt_src_i;
                pend_q    <= dec_i.unc_set;
            end else if (state_q == ST_EMIT) begin
                pend_q    <= '0;
            end
        end
    end

    // R11
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_i && evt_ready_o && dec_i.ok) |=> !evt_ready_o);
    // R1
    reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid_i && evt_ready_o && !dec_i.ok) |=> (evt_ready_o && !msg_valid_o && !log_req_o));
    // R12
    msg_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_o |-> ($countones(msg_sev_o) == 1));
    // R12
    msg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_o |=> !msg_valid_o);
    // R10
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (log_req_o && msg_valid_o && log_ovf_i) |=> (!evt_ready_o && !msg_valid_o));

endmodule

// File: rtl/err_gate.sv
module err_gate
    import err_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    output logic             evt_ready,
    input  logic [IN_W-1:0]  evt_status,
    input  logic             evt_is_cor,
    input  logic             evt_adv_ok,
    input  logic [SRC_W-1:0] evt_src,
    input  logic             sev_we,
    input  logic [UNC_W-1:0] sev_wdata,
    input  logic [UNC_W-1:0] unc_mask,
    input  logic [COR_W-1:0] cor_mask,
    input  logic             serr_en,
    input  logic             cor_rep_en,
    input  logic             nf_rep_en,
    input  logic             fatal_rep_en,
    input  logic             ur_rep_en,
    input  logic [DEV_W-1:0] dev_clr,
    input  logic [COR_W-1:0] cor_clr,
    input  logic [UNC_W-1:0] unc_clr,
    output logic [DEV_W-1:0] dev_status,
    output logic [COR_W-1:0] cor_status,
    output logic [UNC_W-1:0] unc_status,
    output logic [UNC_W-1:0] sev_reg,
    output logic             msg_valid,
    output logic [SEV_W-1:0] msg_sev,
    output logic [SRC_W-1:0] msg_src,
    output logic             log_req,
    output logic [UNC_W-1:0] log_bit,
    output logic [SRC_W-1:0] log_src,
    input  logic             log_ovf
);

    logic [IN_W-1:0]  cls_vec;
    logic             cls_is_cor;
    logic             cls_adv;
    decision_t        dec;
    logic [DEV_W-1:0] dev_set;
    logic [COR_W-1:0] cor_set;
    logic [UNC_W-1:0] unc_set;

    err_gate_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_valid_i  (evt_valid),
        .evt_ready_o  (evt_ready),
        .evt_status_i (evt_status),
        .evt_is_cor_i (evt_is_cor),
        .evt_adv_ok_i (evt_adv_ok),
        .evt_src_i    (evt_src),
        .log_ovf_i    (log_ovf),
        .cls_vec_o    (cls_vec),
        .cls_is_cor_o (cls_is_cor),
        .cls_adv_o    (cls_adv),
        .dec_i        (dec),
        .dev_set_o    (dev_set),
        .cor_set_o    (cor_set),
        .unc_set_o    (unc_set),
        .msg_valid_o  (msg_valid),
        .msg_sev_o    (msg_sev),
        .msg_src_o    (msg_src),
        .log_req_o    (log_req),
        .log_bit_o    (log_bit),
        .log_src_o    (log_src)
    );

    err_gate_classify u_cls (
        .vec_i      (cls_vec),
        .is_cor_i   (cls_is_cor),
        .adv_ok_i   (cls_adv),
        .sev_i      (sev_reg),
        .unc_mask_i (unc_mask),
        .cor_mask_i (cor_mask),
        .serr_en_i  (serr_en),
        .cor_en_i   (cor_rep_en),
        .nf_en_i    (nf_rep_en),
        .fatal_en_i (fatal_rep_en),
        .ur_en_i    (ur_rep_en),
        .dec_o      (dec)
    );

    err_gate_status u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .dev_set_i   (dev_set),
        .cor_set_i   (cor_set),
        .unc_set_i   (unc_set),
        .dev_clr_i   (dev_clr),
        .cor_clr_i   (cor_clr),
        .unc_clr_i   (unc_clr),
        .sev_we_i    (sev_we),
        .sev_wdata_i (sev_wdata),
        .dev_o       (dev_status),
        .cor_o       (cor_status),
        .unc_o       (unc_status),
        .sev_o       (sev_reg)
    );

    // R7
    log_then_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        log_req |=> ((unc_status & $past(log_bit)) == $past(log_bit)));
    // R6
    masked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        log_req |-> ((log_bit & $past(unc_mask)) == '0));

endmodule

// File: tb/err_gate_bench.sv
module err_gate_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic        evt_ready;
    logic [31:0] evt_status = '0;
    logic        evt_is_cor = 1'b0;
    logic        evt_adv_ok = 1'b0;
    logic [15:0] evt_src = '0;
    logic        sev_we = 1'b0;
    logic [15:0] sev_wdata = '0;
    logic [15:0] unc_mask = '0;
    logic [7:0]  cor_mask = '0;
    logic        serr_en = 1'b0, cor_rep_en = 1'b0, nf_rep_en = 1'b0;
    logic        fatal_rep_en = 1'b0, ur_rep_en = 1'b0;
    logic [3:0]  dev_clr = '0;
    logic [7:0]  cor_clr = '0;
    logic [15:0] unc_clr = '0;
    logic [3:0]  dev_status;
    logic [7:0]  cor_status;
    logic [15:0] unc_status;
    logic [15:0] sev_reg;
    logic        msg_valid;
    logic [2:0]  msg_sev;
    logic [15:0] msg_src;
    logic        log_req;
    logic [15:0] log_bit;
    logic [15:0] log_src;
    logic        log_ovf = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    err_gate u_err_gate (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
        .evt_status(evt_status), .evt_is_cor(evt_is_cor), .evt_adv_ok(evt_adv_ok),
        .evt_src(evt_src), .sev_we(sev_we), .sev_wdata(sev_wdata),
        .unc_mask(unc_mask), .cor_mask(cor_mask), .serr_en(serr_en),
        .cor_rep_en(cor_rep_en), .nf_rep_en(nf_rep_en), .fatal_rep_en(fatal_rep_en),
        .ur_rep_en(ur_rep_en), .dev_clr(dev_clr), .cor_clr(cor_clr), .unc_clr(unc_clr),
        .dev_status(dev_status), .cor_status(cor_status), .unc_status(unc_status),
        .sev_reg(sev_reg), .msg_valid(msg_valid), .msg_sev(msg_sev), .msg_src(msg_src),
        .log_req(log_req), .log_bit(log_bit), .log_src(log_src), .log_ovf(log_ovf)
    );

    typedef struct packed {
        logic [31:0] st;
        logic        cor;
        logic        adv;
        logic [15:0] um;
        logic [7:0]  cm;
        logic [4:0]  en;    // serr, cor, nf, fatal, ur
        logic        ovf;
        logic [4:0]  rq;
        logic        acc;
        logic        msg;
        logic [2:0]  sev;
        logic        log;
        logic [3:0]  dev;
        logic [7:0]  ecor;
        logic [15:0] eunc;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        // R3 correctable, reported
        '{32'h2, 1'b1, 1'b0, 16'h0, 8'h00, 5'b11111, 1'b0, 5'd3, 1'b1, 1'b1, 3'b001, 1'b0, 4'h1, 8'h02, 16'h0},
        // R3 correctable, masked
        '{32'h2, 1'b1, 1'b0, 16'h0, 8'h02, 5'b11111, 1'b0, 5'd3, 1'b1, 1'b0, 3'b000, 1'b0, 4'h1, 8'h02, 16'h0},
        // R4 correctable, reporting off
        '{32'h10, 1'b1, 1'b0, 16'h0, 8'h00, 5'b10111, 1'b0, 5'd4, 1'b1, 1'b0, 3'b000, 1'b0, 4'h1, 8'h10, 16'h0},
        // R5 fatal by default severity
        '{32'h1, 1'b0, 1'b0, 16'h0, 8'h00, 5'b00010, 1'b0, 5'd5, 1'b1, 1'b1, 3'b100, 1'b1, 4'h4, 8'h00, 16'h1},
        // R8 nonfatal via system-error enable
        '{32'h4, 1'b0, 1'b0, 16'h0, 8'h00, 5'b10000, 1'b0, 5'd8, 1'b1, 1'b1, 3'b010, 1'b1, 4'h2, 8'h00, 16'h4},
        // R8 nonfatal without any enable
        '{32'h4, 1'b0, 1'b0, 16'h0, 8'h00, 5'b01001, 1'b0, 5'd8, 1'b1, 1'b0, 3'b000, 1'b1, 4'h2, 8'h00, 16'h4},
        // R6 masked uncorrectable
        '{32'h100, 1'b0, 1'b0, 16'h100, 8'h00, 5'b11111, 1'b0, 5'd6, 1'b1, 1'b0, 3'b000, 1'b0, 4'h4, 8'h00, 16'h100},
        // R5 unsupported request, suppressed
        '{32'h400, 1'b0, 1'b0, 16'h0, 8'h00, 5'b00100, 1'b0, 5'd5, 1'b1, 1'b0, 3'b000, 1'b1, 4'hA, 8'h00, 16'h400},
        // R8 unsupported request via system-error enable
        '{32'h400, 1'b0, 1'b0, 16'h0, 8'h00, 5'b10000, 1'b0, 5'd8, 1'b1, 1'b1, 3'b010, 1'b1, 4'hA, 8'h00, 16'h400},
        // R8 unsupported request via its own enable
        '{32'h400, 1'b0, 1'b0, 16'h0, 8'h00, 5'b00101, 1'b0, 5'd8, 1'b1, 1'b1, 3'b010, 1'b1, 4'hA, 8'h00, 16'h400},
        // R9 advisory, logged
        '{32'h10, 1'b0, 1'b1, 16'h0, 8'h00, 5'b11111, 1'b0, 5'd9, 1'b1, 1'b1, 3'b001, 1'b1, 4'h1, 8'h20, 16'h10},
        // R9 advisory, uncorrectable bit masked
        '{32'h10, 1'b0, 1'b1, 16'h10, 8'h00, 5'b11111, 1'b0, 5'd9, 1'b1, 1'b1, 3'b001, 1'b0, 4'h1, 8'h20, 16'h10},
        // R9 advisory, advisory bit masked
        '{32'h10, 1'b0, 1'b1, 16'h0, 8'h20, 5'b11111, 1'b0, 5'd9, 1'b1, 1'b0, 3'b000, 1'b0, 4'h1, 8'h20, 16'h0},
        // R2 fatal bit ignores advisory flag
        '{32'h80, 1'b0, 1'b1, 16'h0, 8'h00, 5'b11111, 1'b0, 5'd2, 1'b1, 1'b1, 3'b100, 1'b1, 4'h4, 8'h00, 16'h80},
        // R4 advisory unsupported request without its enable
        '{32'h400, 1'b0, 1'b1, 16'h0, 8'h00, 5'b01110, 1'b0, 5'd4, 1'b1, 1'b0, 3'b000, 1'b1, 4'h9, 8'h20, 16'h400},
        // R10 overflow with message
        '{32'h20, 1'b0, 1'b0, 16'h0, 8'h00, 5'b11111, 1'b1, 5'd10, 1'b1, 1'b1, 3'b010, 1'b1, 4'h2, 8'h00, 16'h20},
        // R10 overflow without message
        '{32'h20, 1'b0, 1'b0, 16'h0, 8'h00, 5'b00000, 1'b1, 5'd10, 1'b1, 1'b0, 3'b000, 1'b1, 4'h2, 8'h00, 16'h20},
        // R1 two bits
        '{32'h3, 1'b0, 1'b0, 16'h0, 8'h00, 5'b11111, 1'b0, 5'd1, 1'b0, 1'b0, 3'b000, 1'b0, 4'h0, 8'h00, 16'h0},
        // R1 unsupported uncorrectable bit
        '{32'h100000, 1'b0, 1'b0, 16'h0, 8'h00, 5'b11111, 1'b0, 5'd1, 1'b0, 1'b0, 3'b000, 1'b0, 4'h0, 8'h00, 16'h0},
        // R1 bit outside correctable set
        '{32'h100, 1'b1, 1'b0, 16'h0, 8'h00, 5'b11111, 1'b0, 5'd1, 1'b0, 1'b0, 3'b000, 1'b0, 4'h0, 8'h00, 16'h0},
        // R1 empty vector
        '{32'h0, 1'b1, 1'b0, 16'h0, 8'h00, 5'b11111, 1'b0, 5'd1, 1'b0, 1'b0, 3'b000, 1'b0, 4'h0, 8'h00, 16'h0}
    };

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic clear_all();
        @(negedge clk);
        dev_clr = '1; cor_clr = '1; unc_clr = '1;
        @(negedge clk);
        dev_clr = '0; cor_clr = '0; unc_clr = '0;
    endtask

    task automatic set_en(input logic [4:0] en);
        serr_en = en[4]; cor_rep_en = en[3]; nf_rep_en = en[2];
        fatal_rep_en = en[1]; ur_rep_en = en[0];
    endtask

    task automatic run_vec(input int i);
        vec_t  v;
        string rq;
        logic [15:0] src;
        v   = VECS[i];
        rq  = $sformatf("R%0d", v.rq);
        src = 16'hA000 + 16'(i);
        clear_all();
        @(negedge clk);
        unc_mask = v.um; cor_mask = v.cm; set_en(v.en);
        evt_status = v.st; evt_is_cor = v.cor; evt_adv_ok = v.adv; evt_src = src;
        evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
        chk(rq, "ready", 32'(evt_ready), 32'(!v.acc));
        chk(rq, "msg_valid", 32'(msg_valid), 32'(v.msg));
        if (v.msg) begin
            chk(rq, "msg_sev", 32'(msg_sev), 32'(v.sev));
            chk(rq, "msg_src", 32'(msg_src), 32'(src));
        end
        chk(rq, "log_req", 32'(log_req), 32'(v.log));
        if (v.log) begin
            chk(rq, "log_bit", 32'(log_bit), 32'(v.st[15:0]));
            chk(rq, "log_src", 32'(log_src), 32'(src));
        end
        chk(rq, "dev_status", 32'(dev_status), 32'(v.dev));
        chk(rq, "cor_status", 32'(cor_status), 32'(v.ecor));
        chk("R7", "unc_status early", 32'(unc_status), 32'h0);
        log_ovf = v.ovf;
        @(negedge clk);
        log_ovf = 1'b0;
        chk("R12", "msg strobe", 32'(msg_valid), 32'h0);
        chk(rq, "unc_status", 32'(unc_status), 32'(v.eunc));
        if (v.ovf && v.msg) begin
            chk("R11", "ready during follow-up", 32'(evt_ready), 32'h0);
            @(negedge clk);
            chk("R10", "follow-up msg", 32'(msg_valid), 32'h1);
            chk("R10", "follow-up sev", 32'(msg_sev), 32'h1);
            chk("R10", "follow-up src", 32'(msg_src), 32'h0);
            chk("R10", "follow-up cor", 32'(cor_status), 32'(v.ecor | 8'h80));
            chk("R10", "follow-up dev", 32'(dev_status), 32'(v.dev | 4'h1));
            @(negedge clk);
            chk("R11", "ready after follow-up", 32'(evt_ready), 32'h1);
        end else begin
            chk("R11", "ready back", 32'(evt_ready), 32'h1);
            if (v.ovf) begin
                @(negedge clk);
                chk("R10", "no follow-up", 32'(cor_status), 32'(v.ecor));
                chk("R10", "no follow-up msg", 32'(msg_valid), 32'h0);
            end
        end
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R11", "reset ready", 32'(evt_ready), 32'h1);
        chk("R12", "reset msg", 32'(msg_valid), 32'h0);
        chk("R7", "reset log", 32'(log_req), 32'h0);
        chk("R13", "reset dev", 32'(dev_status), 32'h0);
        chk("R13", "reset cor", 32'(cor_status), 32'h0);
        chk("R13", "reset unc", 32'(unc_status), 32'h0);
        chk("R2", "reset severity", 32'(sev_reg), 32'h118B);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R2: severity write turns bit 0 nonfatal
        @(negedge clk);
        sev_we = 1'b1; sev_wdata = 16'h0000;
        @(negedge clk);
        sev_we = 1'b0;
        chk("R2", "severity written", 32'(sev_reg), 32'h0);
        clear_all();
        @(negedge clk);
        unc_mask = '0; cor_mask = '0; set_en(5'b11111);
        evt_status = 32'h1; evt_is_cor = 1'b0; evt_adv_ok = 1'b0; evt_src = 16'h0BAD;
        evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
        chk("R2", "rewritten severity msg", 32'(msg_sev), 32'h2);
        chk("R2", "rewritten severity dev", 32'(dev_status), 32'h2);
        sev_we = 1'b1; sev_wdata = 16'h118B;
        @(negedge clk);
        sev_we = 1'b0;

        // R13: set wins over a same-cycle clear, then clear alone
        clear_all();
        @(negedge clk);
        evt_status = 32'h2; evt_is_cor = 1'b1; evt_valid = 1'b1; cor_clr = 8'h02;
        @(negedge clk);
        evt_valid = 1'b0; cor_clr = 8'h00;
        chk("R13", "set beats clear", 32'(cor_status), 32'h02);
        @(negedge clk);
        cor_clr = 8'h02; dev_clr = 4'h1;
        @(negedge clk);
        cor_clr = 8'h00; dev_clr = 4'h0;
        chk("R13", "clear cor", 32'(cor_status), 32'h00);
        chk("R13", "clear dev", 32'(dev_status), 32'h0);

        // R11: valid held high, one acceptance every two cycles
        @(negedge clk);
        evt_status = 32'h1; evt_is_cor = 1'b1; evt_valid = 1'b1;
        cnt = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (msg_valid) cnt++;
        end
        evt_valid = 1'b0;
        chk("R11", "back-to-back messages", 32'(cnt), 32'd2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule